// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Controller

This block gathers single-cycle event pulses from three sources: two bus-side event groups (`bus0`, `bus1`) and one DMA event group. Each event bit is classed as fatal or nonfatal by a parameter, and each has a mask bit supplied by the surrounding logic. Every source has two storage levels. The first is a visible status register that software reads. The second is a hidden stack register that sits behind it. The block drives two summary pending bits (bus side and DMA side), an active-low interrupt request and a one-cycle halt request for fatal events.

An event that arrives while an interrupt is already pending goes into the stack. The visible status stays as it was. A read-clear pulse on a source empties that source's visible register. If that leaves nothing pending anywhere, every stacked bit moves forward into the visible registers at once. Every read-clear also holds the request line inactive for a minimum gap. After the gap the line reasserts if unmasked work is still pending.

The request logic is a four-state machine:
- `ST_IDLE`: nothing pending.
- `ST_MASKED`: something is pending, but no pending bit came from an unmasked event, so the line stays inactive.
- `ST_REQ`: the line is asserted.
- `ST_GAP`: the forced quiet period after a read-clear.

It has the following transitions:
- `evaluate`: any non-gap state, or `ST_GAP` when its counter reaches zero, moves to `ST_REQ` if an unmasked pending bit will exist. Otherwise it moves to `ST_MASKED` if any pending bit will exist, and to `ST_IDLE` if none will.
- `clear`: any state moves to `ST_GAP` on a read-clear, and the gap counter reloads.
- `count`: `ST_GAP` stays in `ST_GAP` and decrements while its counter is nonzero.

Top module: `stacked_irq_ctrl`

## Requirements
- R1: Every event bit classed as fatal pulses `halt_req` high for exactly the cycle after its arrival edge, whether masked or not and whether stacked or not. A fatal event that lands in the visible register sets its status bit and its group's pending bit.
- R2: A masked fatal event sets status and pending but never causes `irq_n` to go low by itself.
- R3: Once `irq_n` is low, changing mask inputs does not raise it; only a read-clear does.
- R4: When either pending bit is set and no read-clear occurs, a new event leaves every visible status register unchanged and is held in the stack.
- R5: Further events while the stack already holds bits are ORed into the stack; nothing stacked is lost.
- R6: `rd_clr` bit 0 clears `stat_bus0`, bit 1 clears `stat_bus1`, bit 2 clears `stat_dma`; only the selected register is cleared. If no pending bit remains after that, all stacked bits move into the visible registers in the same edge and the stack empties. Otherwise the stack is kept.
- R7: After any read-clear edge, `irq_n` is high for at least 3 cycles. If unmasked pending status exists at the end of the gap, `irq_n` then goes low.
- R8: A masked nonfatal event sets its status bit but sets no pending bit and does not drive `irq_n` low.
- R9: A masked nonfatal status bit does not cause later events to be stacked; they go directly to the visible registers.
- R10: `pend_bus` is the OR of `bus0`/`bus1` status bits set by fatal or unmasked events, and `pend_dma` is the same for the DMA source. `irq_n` is low only when a status bit set by an unmasked event is present and no gap runs.
- R11: An event and a read-clear in the same cycle: the event lands in the visible level if nothing is pending after the clear and any promotion, and in the stack otherwise.
- R12: After reset all status bits, the stack and both pending bits are 0, `irq_n` is 1 and `halt_req` is 0.
- R13: Status bit i of a source corresponds to event bit i of that source, at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bus0 | input | EVW | Event pulses, bus group 0 |
| ev_bus1 | input | EVW | Event pulses, bus group 1 |
| ev_dma | input | EVW | Event pulses, DMA group |
| mask_bus0 | input | EVW | Mask bits for bus group 0 (1 = masked) |
| mask_bus1 | input | EVW | Mask bits for bus group 1 |
| mask_dma | input | EVW | Mask bits for DMA group |
| rd_clr | input | 3 | Read-clear strobes: bit0 bus0, bit1 bus1, bit2 DMA |
| stat_bus0 | output | EVW | Visible status, bus group 0 |
| stat_bus1 | output | EVW | Visible status, bus group 1 |
| stat_dma | output | EVW | Visible status, DMA group |
| pend_bus | output | 1 | Bus-side summary pending |
| pend_dma | output | 1 | DMA-side summary pending |
| irq_n | output | 1 | Interrupt request, active low |
| halt_req | output | 1 | One-cycle halt request on a fatal event |

## Verification
The assertions assume that event inputs are single-cycle pulses with no meaning beyond the edge that samples them. They also assume that masks are quasi-static levels, and that a read-clear is a single-cycle strobe, with several strobes in one cycle permitted. The bench drives every input on the falling edge and returns events and strobes to zero one cycle later, so every pulse is seen by exactly one rising edge. It sweeps every source, bit and mask value from reset. It then builds stacking, promotion, partial-clear and same-cycle event-and-clear sequences whose expected values follow from the parameterised fatal classes.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASKED = 2'd1,
        ST_REQ    = 2'd2,
        ST_GAP    = 2'd3
    } req_state_e;
endpackage

// File: rtl/sic_slice.sv
module sic_slice #(
    parameter int            W     = 4,
    parameter logic [W-1:0]  FATAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] mask,
    input  logic         rd_clr,
    input  logic         promote,
    input  logic         land_stk,
    output logic [W-1:0] vis,
    output logic         pc_left,
    output logic         stk_pc_any,
    output logic         pc_now,
    output logic         um_now,
    output logic         pc_nxt_any,
    output logic         um_nxt_any,
    output logic         fatal_hit
);
    logic [W-1:0] vis_pc, vis_um, stk, stk_pc, stk_um;
    logic [W-1:0] vis_d, vis_pc_d, vis_um_d, stk_d, stk_pc_d, stk_um_d;
    logic [W-1:0] pc_ev, um_ev;

    assign pc_ev = ev & (FATAL | ~mask);
    assign um_ev = ev & ~mask;

    always_comb begin
        vis_d    = rd_clr ? '0 : vis;
        vis_pc_d = rd_clr ? '0 : vis_pc;
        vis_um_d = rd_clr ? '0 : vis_um;
        stk_d    = stk;
        stk_pc_d = stk_pc;
        stk_um_d = stk_um;
        if (promote) begin
            vis_d    = vis_d | stk;
            vis_pc_d = vis_pc_d | stk_pc;
            vis_um_d = vis_um_d | stk_um;
            stk_d    = '0;
            stk_pc_d = '0;
            stk_um_d = '0;
        end
        if (land_stk) begin
            stk_d    = stk_d | ev;
            stk_pc_d = stk_pc_d | pc_ev;
            stk_um_d = stk_um_d | um_ev;
        end else begin
            vis_d    = vis_d | ev;
            vis_pc_d = vis_pc_d | pc_ev;
            vis_um_d = vis_um_d | um_ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis    <= '0;
            vis_pc <= '0;
            vis_um <= '0;
            stk    <= '0;
            stk_pc <= '0;
            stk_um <= '0;
        end else begin
            vis    <= vis_d;
            vis_pc <= vis_pc_d;
            vis_um <= vis_um_d;
            stk    <= stk_d;
            stk_pc <= stk_pc_d;
            stk_um <= stk_um_d;
        end
    end

    assign pc_left    = rd_clr ? 1'b0 : |vis_pc;
    assign stk_pc_any = |stk_pc;
    assign pc_now     = |vis_pc;
    assign um_now     = |vis_um;
    assign pc_nxt_any = |vis_pc_d;
    assign um_nxt_any = |vis_um_d;
    assign fatal_hit  = |(ev & FATAL);

    // R4: stacked arrival leaves the visible level untouched
    assert_vis_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (land_stk && !rd_clr && !promote) |=> $stable(vis));

    // R5: stacked bits accumulate; none is dropped
    assert_stack_accum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (land_stk && !promote) |=> ((stk & $past(ev | stk)) == $past(ev | stk)));

    // R6: promotion empties the stack into the visible level
    assert_promote_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (promote && !land_stk) |=> (stk == '0 && ((vis & $past(stk)) == $past(stk))));
endmodule

// File: rtl/sic_req_fsm.sv
module sic_req_fsm
    import sic_pkg::*;
#(
    parameter int GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_any,
    input  logic pc_nxt,
    input  logic um_nxt,
    output logic irq_n
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    req_state_e    state, state_d;
    logic [CW-1:0] cnt, cnt_d;
    req_state_e    settle;

    always_comb begin
        if (um_nxt)      settle = ST_REQ;
        else if (pc_nxt) settle = ST_MASKED;
        else             settle = ST_IDLE;
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        if (clr_any) begin
            state_d = ST_GAP;
            cnt_d   = CW'(GAP_CYC - 1);
        end else begin
            unique case (state)
                ST_IDLE, ST_MASKED, ST_REQ: state_d = settle;
                ST_GAP: begin
                    if (cnt != '0) cnt_d = cnt - 1'b1;
                    else           state_d = settle;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        irq_n = (state != ST_REQ);
    end

    // R7: a read-clear always enters the gap with a full count
    assert_gap_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (state == ST_GAP && cnt == CW'(GAP_CYC - 1)));

    // R7: the line stays inactive while the gap counter runs
    assert_gap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> irq_n);

    // R3: only a read-clear takes the request away
    assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ && !clr_any) |=> (state == ST_REQ));
endmodule

// File: rtl/stacked_irq_ctrl.sv
module stacked_irq_ctrl
    import sic_pkg::*;
#(
    parameter int              EVW      = 4,
    parameter int              GAP_CYC  = 3,
    parameter logic [EVW-1:0]  FATAL_B0 = EVW'(1),
    parameter logic [EVW-1:0]  FATAL_B1 = EVW'(1),
    parameter logic [EVW-1:0]  FATAL_D  = EVW'(1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] ev_bus0,
    input  logic [EVW-1:0] ev_bus1,
    input  logic [EVW-1:0] ev_dma,
    input  logic [EVW-1:0] mask_bus0,
    input  logic [EVW-1:0] mask_bus1,
    input  logic [EVW-1:0] mask_dma,
    input  logic [2:0]     rd_clr,
    output logic [EVW-1:0] stat_bus0,
    output logic [EVW-1:0] stat_bus1,
    output logic [EVW-1:0] stat_dma,
    output logic           pend_bus,
    output logic           pend_dma,
    output logic           irq_n,
    output logic           halt_req
);
    logic [EVW-1:0] ev_a   [NSRC];
    logic [EVW-1:0] mask_a [NSRC];
    logic [EVW-1:0] vis_a  [NSRC];
    logic [NSRC-1:0] pc_left, stk_pc_any, pc_now, um_now, pc_nxt, um_nxt, fat_hit;
    logic promote, land_stk;

    assign ev_a[0]   = ev_bus0;
    assign ev_a[1]   = ev_bus1;
    assign ev_a[2]   = ev_dma;
    assign mask_a[0] = mask_bus0;
    assign mask_a[1] = mask_bus1;
    assign mask_a[2] = mask_dma;

    assign promote  = (|rd_clr) && !(|pc_left);
    assign land_stk = (|pc_left) || (promote && (|stk_pc_any));

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam logic [EVW-1:0] FAT = (g == 0) ? FATAL_B0 :
                                         (g == 1) ? FATAL_B1 : FATAL_D;
        sic_slice #(.W(EVW), .FATAL(FAT)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev         (ev_a[g]),
            .mask       (mask_a[g]),
            .rd_clr     (rd_clr[g]),
            .promote    (promote),
            .land_stk   (land_stk),
            .vis        (vis_a[g]),
            .pc_left    (pc_left[g]),
            .stk_pc_any (stk_pc_any[g]),
            .pc_now     (pc_now[g]),
            .um_now     (um_now[g]),
            .pc_nxt_any (pc_nxt[g]),
            .um_nxt_any (um_nxt[g]),
            .fatal_hit  (fat_hit[g])
        );
    end

    assign stat_bus0 = vis_a[0];
    assign stat_bus1 = vis_a[1];
    assign stat_dma  = vis_a[2];
    assign pend_bus  = pc_now[0] | pc_now[1];
    assign pend_dma  = pc_now[2];

    sic_req_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_any (|rd_clr),
        .pc_nxt  (|pc_nxt),
        .um_nxt  (|um_nxt),
        .irq_n   (irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_req <= 1'b0;
        else        halt_req <= |fat_hit;
    end

    // R1: a fatal pulse always yields a halt request on the next cycle
    assert_fatal_halts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|fat_hit) |=> halt_req);

    // R2: an asserted request needs status from an unmasked event
    assert_req_needs_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|um_now));

    // R4: the stack only holds bits while something is pending
    assert_stack_needs_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|stk_pc_any) |-> (pend_bus || pend_dma));
endmodule

// File: tb/stacked_irq_ctrl_bench.sv
module stacked_irq_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int EVW   = 2;
    localparam logic [EVW-1:0] FB0 = 2'b10;
    localparam logic [EVW-1:0] FB1 = 2'b00;
    localparam logic [EVW-1:0] FD  = 2'b01;

    logic clk = 1'b0;
    logic rst_n;
    logic [EVW-1:0] ev0, ev1, evd, m0, m1, md;
    logic [2:0] clr;
    logic [EVW-1:0] s0, s1, sd;
    logic pb, pd, irq_n, halt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    stacked_irq_ctrl #(
        .EVW(EVW), .GAP_CYC(3), .FATAL_B0(FB0), .FATAL_B1(FB1), .FATAL_D(FD)
    ) u_stacked_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_bus0(ev0), .ev_bus1(ev1), .ev_dma(evd),
        .mask_bus0(m0), .mask_bus1(m1), .mask_dma(md),
        .rd_clr(clr),
        .stat_bus0(s0), .stat_bus1(s1), .stat_dma(sd),
        .pend_bus(pb), .pend_dma(pd), .irq_n(irq_n), .halt_req(halt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ev0 = '0; ev1 = '0; evd = '0; clr = '0;
        m0 = '0; m1 = '0; md = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive one cycle of stimulus, then return to the falling edge after capture
    task automatic step(input logic [EVW-1:0] a, input logic [EVW-1:0] b,
                        input logic [EVW-1:0] d, input logic [2:0] c);
        ev0 = a; ev1 = b; evd = d; clr = c;
        @(negedge clk);
        ev0 = '0; ev1 = '0; evd = '0; clr = '0;
    endtask

    function automatic bit is_fatal(input int src, input int b);
        logic [EVW-1:0] f;
        f = (src == 0) ? FB0 : (src == 1) ? FB1 : FD;
        return f[b];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12 reset state
        chk("R12 stat", int'({s0, s1, sd}), 0);
        chk("R12 pend", int'({pb, pd}), 0);
        chk("R12 irq_n", int'(irq_n), 1);
        chk("R12 halt", int'(halt), 0);

        // sweep: every source, bit and mask value from a clean state
        for (int src = 0; src < 3; src++) begin
            for (int b = 0; b < EVW; b++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [EVW-1:0] e;
                    bit f, pcls;
                    do_reset();
                    e = EVW'(1 << b);
                    if (m == 1) begin
                        if (src == 0) m0 = e; else if (src == 1) m1 = e; else md = e;
                    end
                    f = is_fatal(src, b);
                    pcls = f || (m == 0);
                    step(src == 0 ? e : '0, src == 1 ? e : '0, src == 2 ? e : '0, 3'b000);
                    // R13 bit position, R1/R8 posting
                    chk("R13 stat", int'(src == 0 ? s0 : src == 1 ? s1 : sd), int'(e));
                    chk("R10 pend_bus", int'(pb), int'(pcls && src < 2));
                    chk("R10 pend_dma", int'(pd), int'(pcls && src == 2));
                    chk(m == 1 ? (f ? "R2 irq_n" : "R8 irq_n") : "R10 irq_n",
                        int'(irq_n), int'(m == 1));
                    chk("R1 halt", int'(halt), int'(f));
                    step('0, '0, '0, 3'(1 << src));
                    chk("R6 cleared", int'({s0, s1, sd}), 0);
                    chk("R7 irq_n gap", int'(irq_n), 1);
                    chk("R1 halt pulse", int'(halt), 0);
                end
            end
        end

        // stacking and promotion
        do_reset();
        step(2'b01, '0, '0, 3'b000);
        chk("R10 irq low", int'(irq_n), 0);
        step('0, '0, 2'b10, 3'b000);
        chk("R4 dma vis", int'(sd), 0);
        chk("R4 pend_dma", int'(pd), 0);
        step('0, 2'b01, '0, 3'b000);
        step('0, 2'b10, '0, 3'b000);
        chk("R5 bus1 vis", int'(s1), 0);
        step('0, '0, '0, 3'b001);
        chk("R6 bus0", int'(s0), 0);
        chk("R6 bus1 promoted", int'(s1), 3);
        chk("R6 dma promoted", int'(sd), 2);
        chk("R6 pend", int'({pb, pd}), 3);
        chk("R7 gap c1", int'(irq_n), 1);
        step('0, '0, '0, 3'b000);
        chk("R7 gap c2", int'(irq_n), 1);
        step('0, '0, '0, 3'b000);
        chk("R7 gap c3", int'(irq_n), 1);
        step('0, '0, '0, 3'b000);
        chk("R7 reassert", int'(irq_n), 0);

        // partial clear keeps stack while another source is pending
        do_reset();
        step(2'b01, 2'b01, '0, 3'b000);
        step('0, '0, 2'b10, 3'b000);
        step('0, '0, '0, 3'b001);
        chk("R6 only bus0 cleared", int'(s1), 1);
        chk("R6 stack kept", int'(sd), 0);
        step('0, '0, '0, 3'b010);
        chk("R6 late promote", int'(sd), 2);

        // masked nonfatal: no stacking behind it
        do_reset();
        m1 = 2'b01;
        step('0, 2'b01, '0, 3'b000);
        chk("R8 stat", int'(s1), 1);
        chk("R8 pend", int'({pb, pd}), 0);
        chk("R8 irq_n", int'(irq_n), 1);
        step('0, '0, 2'b10, 3'b000);
        chk("R9 direct", int'(sd), 2);
        chk("R9 irq", int'(irq_n), 0);

        // masked fatal: pending but quiet; later events stacked
        do_reset();
        m0 = 2'b10;
        step(2'b10, '0, '0, 3'b000);
        chk("R2 stat", int'(s0), 2);
        chk("R2 pend", int'(pb), 1);
        chk("R2 irq_n", int'(irq_n), 1);
        chk("R1 halt masked", int'(halt), 1);
        step('0, 2'b01, '0, 3'b000);
        chk("R4 stacked", int'(s1), 0);
        chk("R2 irq_n kept", int'(irq_n), 1);

        // mask set after assertion
        do_reset();
        step(2'b01, '0, '0, 3'b000);
        m0 = 2'b11; m1 = 2'b11; md = 2'b11;
        step('0, '0, '0, 3'b000);
        step('0, '0, '0, 3'b000);
        chk("R3 irq held", int'(irq_n), 0);

        // same-cycle event and clear, empty stack: lands visible
        do_reset();
        step(2'b01, '0, '0, 3'b000);
        step('0, 2'b10, '0, 3'b001);
        chk("R11 vis land", int'(s1), 2);
        chk("R11 bus0", int'(s0), 0);

        // same-cycle event and clear, stack nonempty: lands in stack
        do_reset();
        step(2'b01, '0, '0, 3'b000);
        step('0, '0, 2'b01, 3'b000);
        chk("R1 halt stacked", int'(halt), 1);
        step('0, 2'b01, '0, 3'b001);
        chk("R11 promoted dma", int'(sd), 1);
        chk("R11 stacked bus1", int'(s1), 0);
        step('0, '0, '0, 3'b100);
        chk("R11 late land", int'(s1), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule